// File: doc/BRIEF.md
# Masked Data Access Breakpoint

This block watches the load/store bus of a CPU and raises a break request when a transaction meets a condition that software has programmed. It has a parameterised number of comparator channels (two by default), and each channel works independently of the others. A channel fires only when all of the following agree in the same cycle:

- the direction of the access (read, write or either);
- the address, which must fall inside an inclusive window;
- the access size, where the filter may also be set to accept any size;
- the data, compared bit by bit under a mask.

Each channel keeps a sticky hit flag that stays set until software clears it. A combined break request pulses one cycle after any matching transaction. The logic that halts the CPU takes that pulse, and software reads the hit flags to find which channel fired.

Configuration goes in through a small write-only register port. Each channel has eight register slots. The channel index sits in the upper bits of the configuration address and the slot index sits in the low three bits. Bus data is presented lane-aligned: a byte at address offset k travels on byte lane k of the data bus.

Top module: `access_watch`

## Requirements
- R1: After a synchronous active-low reset, every hit flag and the break request are 0, and every channel's access type is disabled.
- R2: The access type sits in bits [1:0] of configuration slot 0 of a channel. The values are: 00 never matches, 01 matches reads only (bus_write=0), 10 matches writes only (bus_write=1), and 11 matches either direction.
- R3: The address must lie in the inclusive window lo..hi. The lower bound is configuration slot 1 and the upper bound is slot 2. If the window is empty (lo greater than hi), the channel never matches.
- R4: The size filter sits in bits [3:2] of slot 0. The value 00, 01 or 10 accepts only the equal bus_size (00 byte, 01 halfword, 10 word), and 11 accepts any of those three sizes. A bus_size of 11 never matches.
- R5: Data is compared against slot 3 under the mask in slot 4. A mask bit of 1 removes that data bit from the comparison.
- R6: Only the active byte lanes are compared. A byte access uses lane bus_addr[1:0]. A halfword access uses lanes 2*bus_addr[1] and 2*bus_addr[1]+1. A word access uses all four lanes. Data on the other lanes has no effect.
- R7: No channel matches in a cycle where bus_valid is 0.
- R8: A match sets that channel's hit flag at the next clock edge. The flag then holds until the matching bit of hit_clr is 1 at a clock edge. When a clear and a new match arrive in the same cycle, the match wins.
- R9: brk_req is 1 in exactly the cycle after a cycle in which at least one channel matched, and 0 otherwise. One matching transaction gives a one-cycle pulse.
- R10: Channels are independent. Writes to slots 5 to 7 change no matching behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CAW (4) | {channel index, slot index[2:0]} |
| cfg_wdata | input | DW (32) | Configuration write data |
| bus_valid | input | 1 | Bus transaction strobe |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word |
| bus_addr | input | AW (32) | Transaction byte address |
| bus_data | input | DW (32) | Lane-aligned transaction data |
| hit_clr | input | NCH (2) | Per-channel sticky flag clear |
| hit | output | NCH (2) | Per-channel sticky hit flags |
| brk_req | output | 1 | Break request, one cycle after a match |

## Verification
Two cases are hardest to reach from the ports.

The first is a narrow access whose inactive lanes hold data that would break the comparison. Checking that a match still occurs, and is not merely masked away, takes two steps. The stimulus programs an unmasked word value, then issues byte and halfword accesses in which the active lane is right and the other lanes are deliberately wrong. It then changes only the active lane and expects the match to disappear.

The second is a clear and a new match landing in the same cycle. The bench drives hit_clr together with a matching transaction, so the set-wins rule of R8 is seen directly on the hit output.

// File: rtl/bw_pkg.sv
// Shared encodings for the access watch block.
// Assumes a 2-bit access type and a 2-bit size code in every channel.
package bw_pkg;
    typedef enum logic [1:0] {
        ACC_OFF = 2'b00,
        ACC_RD  = 2'b01,
        ACC_WR  = 2'b10,
        ACC_RW  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_B   = 2'b00,
        SZ_H   = 2'b01,
        SZ_W   = 2'b10,
        SZ_ANY = 2'b11
    } size_e;

    // Channel control word: bits [3:2] size filter, bits [1:0] access type.
    typedef struct packed {
        size_e     wsel;
        acc_kind_e kind;
    } chan_ctrl_t;

    localparam int SLOT_BITS = 3;
endpackage

// File: rtl/bw_cfg_regs.sv
// Configuration register file for all comparator channels.
// Each channel owns 8 slots: 0 control, 1 lower bound, 2 upper bound,
// 3 compare value, 4 compare mask. Slots 5..7 are accepted and dropped.
// Assumes AW <= DW. Reset disables every channel.
module bw_cfg_regs
    import bw_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CAW = CHB + SLOT_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CAW-1:0]           cfg_addr,
    input  logic [DW-1:0]            cfg_wdata,
    output chan_ctrl_t [NCH-1:0]     ctrl_o,
    output logic [NCH-1:0][AW-1:0]   lo_o,
    output logic [NCH-1:0][AW-1:0]   hi_o,
    output logic [NCH-1:0][DW-1:0]   val_o,
    output logic [NCH-1:0][DW-1:0]   mask_o
);
    logic [CHB-1:0]       wr_ch;
    logic [SLOT_BITS-1:0] wr_slot;

    // Split the configuration address into channel and slot.
    always_comb begin
        wr_ch   = cfg_addr[CAW-1:SLOT_BITS];
        wr_slot = cfg_addr[SLOT_BITS-1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        // Decode whether this channel is addressed.
        always_comb sel = cfg_we && (wr_ch == CHB'(c));

        // Per-channel registers with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_o[c] <= '{wsel: SZ_B, kind: ACC_OFF};
                lo_o[c]   <= '0;
                hi_o[c]   <= '0;
                val_o[c]  <= '0;
                mask_o[c] <= '0;
            end else if (sel) begin
                case (wr_slot)
                    3'd0: ctrl_o[c] <= chan_ctrl_t'(cfg_wdata[3:0]);
                    3'd1: lo_o[c]   <= cfg_wdata[AW-1:0];
                    3'd2: hi_o[c]   <= cfg_wdata[AW-1:0];
                    3'd3: val_o[c]  <= cfg_wdata;
                    3'd4: mask_o[c] <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bw_lane_mask.sv
// Expands an access size and low address bits into a bit mask of active
// data lanes (1 = bit takes part in the compare).
// Assumes byte lanes of 8 bits, lane-aligned data, and DW a multiple of 32.
module bw_lane_mask
    import bw_pkg::*;
#(
    parameter int DW = 32,
    localparam int NLANE = DW / 8,
    localparam int LB    = $clog2(NLANE)
) (
    input  logic [LB-1:0] addr_lo,
    input  logic [1:0]    size,
    output logic [DW-1:0] lanes
);
    // Mark each lane active or idle for the current access size.
    always_comb begin
        for (int l = 0; l < NLANE; l++) begin
            logic on;
            case (size)
                SZ_B:    on = (LB'(l) == addr_lo);
                SZ_H:    on = (LB'(l >> 1) == (addr_lo >> 1));
                SZ_W:    on = 1'b1;
                default: on = 1'b0;
            endcase
            lanes[l*8 +: 8] = {8{on}};
        end
    end
endmodule

// File: rtl/bw_chan_match.sv
// One comparator channel: direction, inclusive address window, size filter
// and masked data compare over the active lanes, all combinational.
// Assumes the bus inputs are stable while bus_valid is high.
module bw_chan_match
    import bw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_ctrl_t    ctrl,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] lanes,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          match
);
    logic dir_ok, addr_ok, size_ok, data_ok;
    logic [DW-1:0] care;

    // Direction filter from the access type.
    always_comb begin
        case (ctrl.kind)
            ACC_RD:  dir_ok = !bus_write;
            ACC_WR:  dir_ok = bus_write;
            ACC_RW:  dir_ok = 1'b1;
            default: dir_ok = 1'b0;
        endcase
    end

    // Inclusive window, size filter and masked lane compare.
    always_comb begin
        addr_ok = (bus_addr >= lo) && (bus_addr <= hi);
        size_ok = (bus_size != 2'b11) &&
                  ((ctrl.wsel == SZ_ANY) || (ctrl.wsel == size_e'(bus_size)));
        care    = ~mask & lanes;
        data_ok = ((bus_data ^ val) & care) == '0;
        match   = bus_valid && dir_ok && addr_ok && size_ok && data_ok;
    end

    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.kind == ACC_OFF) |-> !match);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && bus_write) |-> ctrl.kind[1]);
    assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ((bus_addr >= lo) && (bus_addr <= hi)));
    assert_valid_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !match);
endmodule

// File: rtl/access_watch.sv
// Top of the access watch block: configuration registers, one shared lane
// mask, NCH comparator channels, sticky hit flags and a registered break
// request that pulses one cycle after any matching transaction.
// Assumes a synchronous active-low reset and lane-aligned bus data.
module access_watch
    import bw_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int CHB   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CAW   = CHB + SLOT_BITS,
    localparam int NLANE = DW / 8,
    localparam int LB    = $clog2(NLANE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [1:0]     bus_size,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_data,
    input  logic [NCH-1:0] hit_clr,
    output logic [NCH-1:0] hit,
    output logic           brk_req
);
    chan_ctrl_t [NCH-1:0]   ctrl;
    logic [NCH-1:0][AW-1:0] lo, hi;
    logic [NCH-1:0][DW-1:0] val, mask;
    logic [DW-1:0]          lanes;
    logic [NCH-1:0]         match_vec;
    logic [NCH-1:0]         hit_q;
    logic                   brk_q;

    bw_cfg_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl_o(ctrl), .lo_o(lo), .hi_o(hi),
        .val_o(val), .mask_o(mask)
    );

    bw_lane_mask #(.DW(DW)) u_lanes (
        .addr_lo(bus_addr[LB-1:0]), .size(bus_size), .lanes(lanes)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bw_chan_match #(.AW(AW), .DW(DW)) u_match (
            .clk(clk), .rst_n(rst_n), .ctrl(ctrl[c]), .lo(lo[c]), .hi(hi[c]),
            .val(val[c]), .mask(mask[c]), .lanes(lanes),
            .bus_valid(bus_valid), .bus_write(bus_write),
            .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
            .match(match_vec[c])
        );

        assert_hit_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_q[c] && !hit_clr[c]) |=> hit_q[c]);
        assert_hit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit_q[c] && !match_vec[c]) |=> !hit_q[c]);
    end

    // Sticky hit flags (set beats clear) and the one-cycle break pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
            brk_q <= 1'b0;
        end else begin
            hit_q <= (hit_q & ~hit_clr) | match_vec;
            brk_q <= |match_vec;
        end
    end

    assign hit     = hit_q;
    assign brk_req = brk_q;

    assert_brk_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_vec) |=> brk_q);
    assert_brk_has_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> (|hit_q));
endmodule

// File: tb/access_watch_bench.sv
module access_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        bus_valid, bus_write;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_data;
    logic [1:0]  hit_clr;
    logic [1:0]  hit;
    logic        brk_req;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    logic [1:0]  m_kind [NCH];
    logic [1:0]  m_wsel [NCH];
    logic [31:0] m_lo [NCH], m_hi [NCH], m_val [NCH], m_mask [NCH];
    logic [1:0]  e_hit;
    logic        e_brk;

    always #(CLK_PERIOD/2) clk = ~clk;

    access_watch u_access_watch (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data),
        .hit_clr(hit_clr), .hit(hit), .brk_req(brk_req)
    );

    function automatic logic ref_match(int ch);
        logic [31:0] act;
        bit dir, sz;
        if (!bus_valid) return 1'b0;
        case (bus_size)
            2'b00: act = 32'hFF << (8 * bus_addr[1:0]);
            2'b01: act = 32'hFFFF << (16 * bus_addr[1]);
            2'b10: act = 32'hFFFF_FFFF;
            default: return 1'b0;
        endcase
        dir = (m_kind[ch] == 2'b11) || (m_kind[ch] == 2'b01 && !bus_write)
           || (m_kind[ch] == 2'b10 && bus_write);
        sz  = (m_wsel[ch] == 2'b11) || (m_wsel[ch] == bus_size);
        return dir && sz && (bus_addr >= m_lo[ch]) && (bus_addr <= m_hi[ch])
            && (((bus_data ^ m_val[ch]) & ~m_mask[ch] & act) == 0);
    endfunction

    task automatic compare(string tag);
        checks++;
        if (hit !== e_hit) begin
            errors++;
            $display("FAIL %s hit: actual %b expected %b", tag, hit, e_hit);
        end
        checks++;
        if (brk_req !== e_brk) begin
            errors++;
            $display("FAIL %s brk_req: actual %b expected %b", tag, brk_req, e_brk);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_kind[c] = 0; m_wsel[c] = 0; m_lo[c] = 0; m_hi[c] = 0;
            m_val[c] = 0; m_mask[c] = 0;
        end
        e_hit = 0; e_brk = 0;
    endtask

    // One bus cycle: drive at negedge, model at the edge, compare after it.
    task automatic step(string tag, logic v, logic wr, logic [1:0] sz,
                        logic [31:0] a, logic [31:0] d, logic [1:0] clr);
        logic [1:0] m;
        bus_valid = v; bus_write = wr; bus_size = sz; bus_addr = a;
        bus_data = d; hit_clr = clr;
        #1;
        for (int c = 0; c < NCH; c++) m[c] = ref_match(c);
        @(posedge clk); #1;
        e_hit = (e_hit & ~clr) | m;
        e_brk = |m;
        compare(tag);
        @(negedge clk);
        bus_valid = 0; hit_clr = 0;
    endtask

    task automatic cfg_wr(int ch, int slot, logic [31:0] d);
        cfg_we = 1; cfg_addr = 4'(ch * 8 + slot); cfg_wdata = d;
        @(posedge clk); #1;
        case (slot)
            0: begin m_kind[ch] = d[1:0]; m_wsel[ch] = d[3:2]; end
            1: m_lo[ch] = d;
            2: m_hi[ch] = d;
            3: m_val[ch] = d;
            4: m_mask[ch] = d;
            default: ;
        endcase
        e_brk = 0;
        compare("R10_cfg");
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic setup(int ch, logic [1:0] kind, logic [1:0] wsel,
                         logic [31:0] lo, logic [31:0] hi,
                         logic [31:0] v, logic [31:0] mk);
        cfg_wr(ch, 0, {28'd0, wsel, kind});
        cfg_wr(ch, 1, lo);
        cfg_wr(ch, 2, hi);
        cfg_wr(ch, 3, v);
        cfg_wr(ch, 4, mk);
    endtask

    task automatic clear_all();
        step("R8_clear", 0, 0, 0, 0, 0, 2'b11);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        bus_valid = 0; bus_write = 0; bus_size = 0; bus_addr = 0;
        bus_data = 0; hit_clr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 compare("R1_reset");
        @(negedge clk);
        rst_n = 1;
        // R1: channels disabled after reset, even for an all-zero access.
        step("R1_disabled", 1, 0, 2'b10, 0, 0, 0);
        step("R1_disabled_wr", 1, 1, 2'b00, 0, 0, 0);

        // R3 window edges, R2 read only, data fully masked.
        setup(0, 2'b01, 2'b11, 32'h1000, 32'h10FF, 0, 32'hFFFF_FFFF);
        step("R3_lo_edge", 1, 0, 2'b10, 32'h1000, 32'h5, 0);
        step("R8_hold", 0, 0, 0, 0, 0, 0);
        step("R8_hold2", 0, 0, 0, 0, 0, 0);
        clear_all();
        step("R3_hi_edge", 1, 0, 2'b10, 32'h10FF, 0, 0);
        clear_all();
        step("R3_below", 1, 0, 2'b10, 32'h0FFF, 0, 0);
        step("R3_above", 1, 0, 2'b10, 32'h1100, 0, 0);
        step("R2_rd_only_rejects_wr", 1, 1, 2'b10, 32'h1010, 0, 0);
        step("R7_invalid", 0, 0, 2'b10, 32'h1010, 0, 0);

        // R2 write only and either direction.
        cfg_wr(0, 0, {28'd0, 2'b11, 2'b10});
        step("R2_wr_only_rejects_rd", 1, 0, 2'b10, 32'h1010, 0, 0);
        step("R2_wr_only_hit", 1, 1, 2'b10, 32'h1010, 0, 0);
        clear_all();
        cfg_wr(0, 0, {28'd0, 2'b11, 2'b11});
        step("R2_rw_rd", 1, 0, 2'b00, 32'h1011, 0, 0);
        clear_all();
        step("R2_rw_wr", 1, 1, 2'b01, 32'h1012, 0, 0);
        clear_all();

        // R4 size filter on channel 1 (halfword only).
        setup(1, 2'b11, 2'b01, 32'h2000, 32'h2FFF, 0, 32'hFFFF_FFFF);
        step("R4_byte_rejected", 1, 0, 2'b00, 32'h2000, 0, 0);
        step("R4_word_rejected", 1, 0, 2'b10, 32'h2000, 0, 0);
        step("R4_half_hit", 1, 0, 2'b01, 32'h2002, 0, 0);
        clear_all();
        step("R4_size11_never", 1, 0, 2'b11, 32'h2000, 0, 0);
        step("R4_any_size11", 1, 0, 2'b11, 32'h1000, 0, 0);

        // R5 mask: only bits [15:8] compared.
        setup(0, 2'b11, 2'b11, 32'h3000, 32'h3003, 32'h0000_AB00, 32'hFFFF_00FF);
        step("R5_masked_hit", 1, 0, 2'b10, 32'h3000, 32'h1234_AB99, 0);
        clear_all();
        step("R5_unmasked_miss", 1, 0, 2'b10, 32'h3000, 32'h1234_AC99, 0);

        // R6 byte lanes with an unmasked word value.
        setup(0, 2'b11, 2'b11, 32'h4000, 32'h4003, 32'h1122_3344, 0);
        step("R6_byte2_hit", 1, 0, 2'b00, 32'h4002, 32'hEE22_DDCC, 0);
        clear_all();
        step("R6_byte2_miss", 1, 0, 2'b00, 32'h4002, 32'h0023_0000, 0);
        step("R6_half_hi_hit", 1, 1, 2'b01, 32'h4002, 32'h1122_0000, 0);
        clear_all();
        step("R6_half_lo_miss", 1, 1, 2'b01, 32'h4000, 32'h1122_0000, 0);
        step("R6_word_miss", 1, 0, 2'b10, 32'h4000, 32'h1122_3345, 0);

        // R8 set wins over a simultaneous clear; R9 pulse.
        step("R6_byte0_hit", 1, 0, 2'b00, 32'h4000, 32'h0000_0044, 0);
        step("R8_set_wins", 1, 0, 2'b00, 32'h4000, 32'h0000_0044, 2'b01);
        step("R9_pulse_drops", 0, 0, 0, 0, 0, 0);
        step("R8_clear_only", 0, 0, 0, 0, 0, 2'b01);

        // R10 both channels together, then independence and dead slots.
        setup(1, 2'b11, 2'b11, 32'h4000, 32'h4000, 0, 32'hFFFF_FFFF);
        step("R10_both_hit", 1, 0, 2'b10, 32'h4000, 32'h1122_3344, 0);
        step("R10_clear_ch1", 0, 0, 0, 0, 0, 2'b10);
        step("R10_ch1_only", 1, 0, 2'b10, 32'h4000, 32'hDEAD_BEEF, 2'b01);
        clear_all();
        cfg_wr(1, 5, 32'hFFFF_FFFF);
        cfg_wr(1, 7, 32'h0);
        step("R10_slot_ignored", 1, 0, 2'b10, 32'h4000, 32'h0, 0);
        clear_all();

        // R3 empty window.
        setup(0, 2'b11, 2'b11, 32'h5001, 32'h5000, 0, 32'hFFFF_FFFF);
        step("R3_empty_window", 1, 0, 2'b10, 32'h5000, 0, 0);
        step("R3_empty_window2", 1, 0, 2'b10, 32'h5001, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule